// File: doc/BRIEF.md
# Load/Store Address Generator

This block sits in the issue path of a load/store pipe. Each cycle it may receive one 32-bit memory-class instruction word with a valid strobe. It decodes the word and names the base and index registers to the register file. It takes the two register values back in the same cycle and forms the 64-bit effective address.

One clock later it presents the registered address, the transfer size, the direction, the data register and a fused-prefix marker. It also raises a misalignment fault for the access kinds that demand alignment.

Three register numbers are special. Register 15 in the index slot reads as zero. In the base slot it is redirected to register 31, the stack pointer. In the data slot it marks the word as a prefix that fuses with the next instruction.

Top module: `ldst_agen`

## Requirements
- R1: A valid strobe with bit 0 of the word set gives `vld_o` high exactly one clock later. With no strobe, or with bit 0 clear, `vld_o` and `fault_o` are low one clock later. Field layout, high to low: imm[31:18], stop[17], store[16], fp-domain[15], base[14:11], index[10:7], data[6:3], scale[2:1], class[0].
- R2: `addr_o` equals base + (index << scale) + sign-extended 14-bit immediate, wrapping modulo 2^64.
- R3: An index field of 15 contributes zero to the address, whatever the index register holds.
- R4: A base field of 15 drives `rd_base_idx_o` to 31, and the stack pointer value is used as the base. Any other base field value n drives n.
- R5: A data field of 15 sets `prefix_o`; any other value clears it. `data_reg_o` always carries the data field.
- R6: `size_o` is log2 of the byte count. With the fp-domain bit clear it equals scale (1 to 8 bytes). With it set it equals scale+2 (4 to 32 bytes).
- R7: `store_o` copies bit 16 of the accepted word.
- R8: A 32-byte access (fp-domain set, scale 3) faults unless address bits [4:0] are zero.
- R9: An fp-domain access with scale 1 (double domain, 8 bytes) faults unless address bits [1:0] are zero.
- R10: All other accesses never fault, whatever their alignment, including 16-byte and integer accesses.
- R11: The stop bit has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word valid this cycle |
| insn_i | input | 32 | Instruction word |
| rd_base_idx_o | output | 5 | Register number read for the base |
| rd_index_idx_o | output | 4 | Register number read for the index |
| rd_base_val_i | input | 64 | Base register value, same cycle |
| rd_index_val_i | input | 64 | Index register value, same cycle |
| vld_o | output | 1 | Registered result valid |
| addr_o | output | 64 | Effective address |
| size_o | output | 3 | log2 of access bytes |
| store_o | output | 1 | Access is a store |
| data_reg_o | output | 4 | Data register field |
| prefix_o | output | 1 | Word is a fused prefix |
| fault_o | output | 1 | Misalignment fault |

## Verification
The register-read numbers are combinational and are due in the same cycle as the strobe. Every other output is due one clock after it. The driver changes inputs on the falling edge. For each cycle it queues one expected item, including idle and non-memory cycles, which expect `vld_o` and `fault_o` low. The monitor samples a quarter period after the next rising edge and pops exactly one item, so each result is compared in the cycle it is due and a late or early output shows as a miscompare.

// File: rtl/ldst_agen_pkg.sv
package ldst_agen_pkg;
  localparam int unsigned INSN_W  = 32;
  localparam int unsigned RFLD_W  = 4;
  localparam int unsigned IMM_W   = 14;
  localparam int unsigned RNUM_W  = 5;
  localparam logic [RFLD_W-1:0] RFLD_SPECIAL = 4'd15;
  localparam logic [RNUM_W-1:0] RNUM_SP      = 5'd31;

  typedef struct packed {
    logic [IMM_W-1:0]  imm;
    logic              stop;
    logic              store;
    logic              fp_dom;
    logic [RFLD_W-1:0] base;
    logic [RFLD_W-1:0] index;
    logic [RFLD_W-1:0] data;
    logic [1:0]        scale;
    logic              is_ls;
  } ls_word_t;

  typedef enum logic [1:0] {
    ALN_FREE = 2'd0,
    ALN_WORD = 2'd1,
    ALN_WIDE = 2'd2
  } align_cls_e;
endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
  import ldst_agen_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output logic [RNUM_W-1:0] base_sel_o,
  output logic [RFLD_W-1:0] index_sel_o,
  output logic              index_zero_o,
  output logic [1:0]        scale_o,
  output logic [IMM_W-1:0]  imm_o,
  output logic [2:0]        size_log2_o,
  output align_cls_e        align_cls_o,
  output logic              store_o,
  output logic              prefix_o,
  output logic [RFLD_W-1:0] data_reg_o,
  output logic              is_ls_o
);
  ls_word_t w;
  assign w = ls_word_t'(insn_i);

  // base slot 15 is redirected to the stack pointer
  assign base_sel_o   = (w.base == RFLD_SPECIAL) ? RNUM_SP : {1'b0, w.base};
  assign index_sel_o  = w.index;
  assign index_zero_o = (w.index == RFLD_SPECIAL);
  assign scale_o      = w.scale;
  assign imm_o        = w.imm;
  assign store_o      = w.store;
  assign prefix_o     = (w.data == RFLD_SPECIAL);
  assign data_reg_o   = w.data;
  assign is_ls_o      = w.is_ls;

  always_comb begin
    size_log2_o = w.fp_dom ? ({1'b0, w.scale} + 3'd2) : {1'b0, w.scale};
    align_cls_o = ALN_FREE;
    if (w.fp_dom && w.scale == 2'd3) align_cls_o = ALN_WIDE;
    else if (w.fp_dom && w.scale == 2'd1) align_cls_o = ALN_WORD;
  end
endmodule

// File: rtl/ldst_addr.sv
module ldst_addr #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IMM_W  = 14
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic              index_zero_i,
  input  logic [1:0]        scale_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [ADDR_W-1:0] ea_o
);
  localparam int unsigned EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] idx_eff, idx_scaled, imm_ext;

  assign idx_eff = index_zero_i ? '0 : index_i;
  assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};

  always_comb begin
    unique case (scale_i)
      2'd0:    idx_scaled = idx_eff;
      2'd1:    idx_scaled = {idx_eff[ADDR_W-2:0], 1'b0};
      2'd2:    idx_scaled = {idx_eff[ADDR_W-3:0], 2'b0};
      default: idx_scaled = {idx_eff[ADDR_W-4:0], 3'b0};
    endcase
  end

  // modulo 2^ADDR_W, carry out discarded
  assign ea_o = base_i + idx_scaled + imm_ext;
endmodule

// File: rtl/ldst_align.sv
module ldst_align
  import ldst_agen_pkg::*;
#(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned WORD_LOG2 = 2,
  parameter int unsigned WIDE_LOG2 = 5
) (
  input  logic [ADDR_W-1:0] ea_i,
  input  align_cls_e        cls_i,
  output logic              misalign_o
);
  logic word_off, wide_off;
  assign word_off = |ea_i[WORD_LOG2-1:0];
  assign wide_off = |ea_i[WIDE_LOG2-1:0];

  always_comb begin
    unique case (cls_i)
      ALN_WORD: misalign_o = word_off;
      ALN_WIDE: misalign_o = wide_off;
      default:  misalign_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ldst_agen.sv
module ldst_agen
  import ldst_agen_pkg::*;
#(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned WORD_LOG2 = 2,
  parameter int unsigned WIDE_LOG2 = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [INSN_W-1:0] insn_i,
  output logic [RNUM_W-1:0] rd_base_idx_o,
  output logic [RFLD_W-1:0] rd_index_idx_o,
  input  logic [ADDR_W-1:0] rd_base_val_i,
  input  logic [ADDR_W-1:0] rd_index_val_i,
  output logic              vld_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [2:0]        size_o,
  output logic              store_o,
  output logic [RFLD_W-1:0] data_reg_o,
  output logic              prefix_o,
  output logic              fault_o
);
  logic              index_zero, d_store, d_prefix, d_is_ls, misalign, accept;
  logic [1:0]        scale;
  logic [IMM_W-1:0]  imm;
  logic [2:0]        size_log2;
  logic [RFLD_W-1:0] data_reg;
  logic [ADDR_W-1:0] ea;
  align_cls_e        align_cls;

  ldst_decode u_dec (
    .insn_i      (insn_i),
    .base_sel_o  (rd_base_idx_o),
    .index_sel_o (rd_index_idx_o),
    .index_zero_o(index_zero),
    .scale_o     (scale),
    .imm_o       (imm),
    .size_log2_o (size_log2),
    .align_cls_o (align_cls),
    .store_o     (d_store),
    .prefix_o    (d_prefix),
    .data_reg_o  (data_reg),
    .is_ls_o     (d_is_ls)
  );

  ldst_addr #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_addr (
    .base_i      (rd_base_val_i),
    .index_i     (rd_index_val_i),
    .index_zero_i(index_zero),
    .scale_i     (scale),
    .imm_i       (imm),
    .ea_o        (ea)
  );

  ldst_align #(.ADDR_W(ADDR_W), .WORD_LOG2(WORD_LOG2), .WIDE_LOG2(WIDE_LOG2)) u_aln (
    .ea_i      (ea),
    .cls_i     (align_cls),
    .misalign_o(misalign)
  );

  assign accept = valid_i & d_is_ls;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      vld_o   <= accept;
      fault_o <= accept & misalign;
    end
  end

  // payload only loads on an accepted word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o     <= '0;
      size_o     <= '0;
      store_o    <= 1'b0;
      data_reg_o <= '0;
      prefix_o   <= 1'b0;
    end else if (accept) begin
      addr_o     <= ea;
      size_o     <= size_log2;
      store_o    <= d_store;
      data_reg_o <= data_reg;
      prefix_o   <= d_prefix;
    end
  end
endmodule

// File: rtl/ldst_agen_chk.sv
module ldst_agen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [31:0] insn_i,
  input logic [4:0]  rd_base_idx_o,
  input logic        vld_o,
  input logic [4:0]  addr_lo,
  input logic [2:0]  size_o,
  input logic [3:0]  data_reg_o,
  input logic        prefix_o,
  input logic        fault_o
);
  a_r1_vld_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && insn_i[0]) |=> vld_o);

  a_r1_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && insn_i[0]) |=> (!vld_o && !fault_o));

  a_r4_sp_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_i[14:11] == 4'd15) |-> (rd_base_idx_o == 5'd31));

  a_r5_prefix_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (prefix_o == (data_reg_o == 4'd15)));

  a_r8_wide_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && size_o == 3'd5 && addr_lo != 5'd0) |-> fault_o);

  a_r10_no_fault_small: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && (size_o == 3'd0 || size_o == 3'd1 || size_o == 3'd2 || size_o == 3'd4)) |-> !fault_o);

  a_r1_fault_needs_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> vld_o);
endmodule

bind ldst_agen ldst_agen_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .insn_i       (insn_i),
  .rd_base_idx_o(rd_base_idx_o),
  .vld_o        (vld_o),
  .addr_lo      (addr_o[4:0]),
  .size_o       (size_o),
  .data_reg_o   (data_reg_o),
  .prefix_o     (prefix_o),
  .fault_o      (fault_o)
);

// File: tb/ldst_agen_tb.sv
module ldst_agen_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        vld;
    logic [63:0] addr;
    logic [2:0]  size;
    logic        store;
    logic [3:0]  dreg;
    logic        prefix;
    logic        fault;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] insn = '0;
  logic [4:0]  rb_idx;
  logic [3:0]  ri_idx;
  logic [63:0] rb_val, ri_val;
  logic        vld, store, prefix, fault;
  logic [63:0] addr;
  logic [2:0]  size;
  logic [3:0]  dreg;

  logic [63:0] regs [32];
  exp_t        sb [$];
  int          n_chk = 0, n_fail = 0;
  bit          mon_on = 1'b0, done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rb_val = regs[rb_idx];
  assign ri_val = regs[{1'b0, ri_idx}];

  ldst_agen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .insn_i(insn),
    .rd_base_idx_o(rb_idx), .rd_index_idx_o(ri_idx),
    .rd_base_val_i(rb_val), .rd_index_val_i(ri_val),
    .vld_o(vld), .addr_o(addr), .size_o(size), .store_o(store),
    .data_reg_o(dreg), .prefix_o(prefix), .fault_o(fault)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [13:0] imm, input bit stop, input bit st,
                                     input bit fp, input logic [3:0] b, input logic [3:0] x,
                                     input logic [3:0] d, input logic [1:0] sc, input bit cls);
    return {imm, stop, st, fp, b, x, d, sc, cls};
  endfunction

  // reference model from the requirements
  function automatic exp_t model(input bit v, input logic [31:0] w, input string tag);
    exp_t e;
    logic [63:0] b, x, im;
    logic [2:0]  sz;
    e.tag   = tag;
    e.vld   = v && w[0];
    b  = (w[14:11] == 4'd15) ? regs[31] : regs[{1'b0, w[14:11]}];
    x  = (w[10:7] == 4'd15) ? 64'd0 : regs[{1'b0, w[10:7]}];
    im = {{50{w[31]}}, w[31:18]};
    e.addr  = b + (x << w[2:1]) + im;
    sz = w[15] ? (3'(w[2:1]) + 3'd2) : 3'(w[2:1]);
    e.size  = sz;
    e.store = w[16];
    e.dreg  = w[6:3];
    e.prefix = (w[6:3] == 4'd15);
    e.fault = 1'b0;
    if (e.vld && w[15] && w[2:1] == 2'd3) e.fault = (e.addr[4:0] != 0);
    if (e.vld && w[15] && w[2:1] == 2'd1) e.fault = (e.addr[1:0] != 0);
    return e;
  endfunction

  task automatic drive(input bit v, input logic [31:0] w, input string tag);
    @(negedge clk);
    valid = v;
    insn  = w;
    sb.push_back(model(v, w, tag));
  endtask

  // monitor: one item per cycle, sampled after the capturing edge
  always @(posedge clk) begin
    if (mon_on && sb.size() > 0) begin
      #(CLK_PERIOD/4);
      begin
        exp_t e;
        e = sb.pop_front();
        chk(vld === e.vld, {e.tag, " vld"}, 64'(vld), 64'(e.vld));
        chk(fault === e.fault, {e.tag, " fault"}, 64'(fault), 64'(e.fault));
        if (e.vld) begin
          chk(addr === e.addr, {e.tag, " addr"}, addr, e.addr);
          chk(size === e.size, {e.tag, " size"}, 64'(size), 64'(e.size));
          chk(store === e.store, {e.tag, " store"}, 64'(store), 64'(e.store));
          chk(dreg === e.dreg, {e.tag, " dreg"}, 64'(dreg), 64'(e.dreg));
          chk(prefix === e.prefix, {e.tag, " prefix"}, 64'(prefix), 64'(e.prefix));
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 64'h0123_4567_0000_0000 + 64'(i) * 64'h1111;
    regs[1]  = 64'h0000_0000_0000_1000;
    regs[2]  = 64'h0000_0000_0000_0003;
    regs[3]  = 64'hFFFF_FFFF_FFFF_FFF8;
    regs[4]  = 64'h0000_0000_0000_0020;
    regs[15] = 64'hDEAD_BEEF_0000_0004;
    regs[31] = 64'h0000_7FFF_FFF0_0000;

    repeat (3) @(posedge clk);
    #1;
    chk(vld === 1'b0 && fault === 1'b0, "R1 reset state", {62'd0, vld, fault}, 64'd0);
    chk(addr === 64'd0, "R1 reset addr", addr, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;

    // R2 basic sums, each scale
    for (int s = 0; s < 4; s++)
      drive(1, mk(14'd12, 0, 0, 0, 4'd1, 4'd2, 4'd5, 2'(s), 1), "R2 R6 int scale");
    drive(1, mk(14'h3FFC, 0, 1, 0, 4'd1, 4'd4, 4'd6, 2'd2, 1), "R2 R7 neg imm store");
    // R2 wraparound
    drive(1, mk(14'd16, 0, 0, 0, 4'd3, 4'd2, 4'd1, 2'd0, 1), "R2 wrap");
    // R3 index 15 reads as zero
    drive(1, mk(14'd4, 0, 0, 0, 4'd1, 4'd15, 4'd2, 2'd3, 1), "R3 zero index");
    // R4 base 15 -> stack pointer
    @(negedge clk);
    valid = 1'b1; insn = mk(14'd8, 0, 0, 0, 4'd15, 4'd1, 4'd2, 2'd0, 1);
    sb.push_back(model(1'b1, insn, "R4 sp base"));
    #1 chk(rb_idx === 5'd31, "R4 read idx", 64'(rb_idx), 64'd31);
    @(negedge clk);
    valid = 1'b1; insn = mk(14'd8, 0, 0, 0, 4'd7, 4'd1, 4'd2, 2'd0, 1);
    sb.push_back(model(1'b1, insn, "R4 plain base"));
    #1 chk(rb_idx === 5'd7, "R4 read idx plain", 64'(rb_idx), 64'd7);
    // R5 prefix slot
    drive(1, mk(14'd0, 0, 1, 0, 4'd1, 4'd2, 4'd15, 2'd1, 1), "R5 prefix");
    drive(1, mk(14'd0, 0, 0, 0, 4'd1, 4'd2, 4'd14, 2'd1, 1), "R5 not prefix");
    // R6 fp sizes, R10 free alignment
    drive(1, mk(14'd1, 0, 0, 1, 4'd1, 4'd15, 4'd3, 2'd0, 1), "R6 R10 single odd");
    drive(1, mk(14'd3, 0, 0, 1, 4'd1, 4'd15, 4'd3, 2'd2, 1), "R6 R10 quad odd");
    drive(1, mk(14'd5, 0, 0, 0, 4'd1, 4'd15, 4'd3, 2'd3, 1), "R10 int8 odd");
    // R8 wide
    drive(1, mk(14'd0, 0, 0, 1, 4'd4, 4'd15, 4'd3, 2'd3, 1), "R8 wide aligned");
    drive(1, mk(14'd16, 0, 1, 1, 4'd4, 4'd15, 4'd3, 2'd3, 1), "R8 wide off16");
    drive(1, mk(14'd0, 0, 0, 1, 4'd2, 4'd15, 4'd3, 2'd3, 1), "R8 wide off3");
    // R9 double domain
    drive(1, mk(14'd4, 0, 0, 1, 4'd1, 4'd15, 4'd3, 2'd1, 1), "R9 dbl word aligned");
    drive(1, mk(14'd2, 0, 0, 1, 4'd1, 4'd15, 4'd3, 2'd1, 1), "R9 dbl off2");
    // R1 idle, class clear
    drive(0, mk(14'd2, 0, 0, 1, 4'd1, 4'd15, 4'd3, 2'd1, 1), "R1 no strobe");
    drive(1, mk(14'd2, 0, 0, 1, 4'd1, 4'd15, 4'd3, 2'd1, 0), "R1 class clear");
    // R11 stop bit
    drive(1, mk(14'd2, 1, 0, 1, 4'd1, 4'd15, 4'd3, 2'd1, 1), "R11 stop set");
    drive(1, mk(14'd9, 1, 1, 0, 4'd3, 4'd4, 4'd15, 2'd2, 1), "R11 stop prefix");
    // sweep
    for (int k = 0; k < 40; k++)
      drive(1, mk(14'(k * 517), k[0], k[1], k[2], 4'(k * 3), 4'(k * 5), 4'(k * 7), 2'(k), 1),
            "R2 R6 sweep");
    drive(0, 32'd0, "R1 drain");
    valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule